// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block sits on the device side of a receive path. It takes frames from a local stream input and places each one into a host buffer. The host buffers are listed in a circular ring of 16-byte descriptors in host memory. Software sets the ring's location, its length in descriptors and a tail index through a small register write port, then sets the enable bit. The engine keeps its own head index. For each frame it reads the descriptor at the head to learn the buffer address. It copies the frame beat by beat from its FIFO into that buffer over a single memory request port. It then overwrites the descriptor with the byte count and a done flag, and moves the head one slot forward.

The ring is shared with software. The done flag marks a slot as filled and owned by software. Software refills a slot by writing a fresh buffer address with the done flag clear, and then writing the tail register. When head equals tail the engine treats the ring as having no free slots. The frame stays in the FIFO, and once the FIFO is full the input stream is held back through its ready signal.

Top module: `rxr_dma_top`

## Requirements
- R1: After reset, `mem_req` is 0, `in_ready` is 1 and the head index is 0.
- R2: Register writes use `reg_sel` 0 for the ring base address (bits 3:0 are ignored), 1 for the ring size in descriptors, 2 for the tail index and 3 for control, where bit 0 is enable. While enable is 0 or the size is 0, no memory request is made.
- R3: The engine reads the descriptor at base + 16 × head as one 64-bit word. Bits 31:0 of that word give the buffer address. Bit 63 is the done flag.
- R4: The head advances by one when the descriptor write-back is accepted, and it goes to 0 after size − 1.
- R5: While head equals tail, no descriptor is read and nothing is written. The pending frame stays queued.
- R6: The write-back goes to the same descriptor address. Its word has bit 63 = 1, bits 47:32 = frame length in bytes, bits 31:0 = the unchanged buffer address, and every other bit 0.
- R7: The write-back is requested only after every data beat of the frame has been accepted.
- R8: Beat k of a frame (counting from 0) is written unchanged to buffer address + 8k, in order.
- R9: The length field equals 8 × the number of beats received, with the trailing CRC beat included.
- R10: A fetched descriptor that still has done = 1 is not used. Nothing is written, and the engine makes no new descriptor read until the tail register is written again.
- R11: `in_ready` goes low while the FIFO is full. No accepted beat is lost or reordered.
- R12: A memory request holds its address, data and direction until `mem_gnt`. Read data is taken on `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Frame beat valid |
| in_data | input | DATA_W | Frame beat data |
| in_last | input | 1 | Final beat of the frame |
| in_ready | output | 1 | FIFO can take a beat |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
The hardest state to reach is a slot that the tail has made available but software has not yet refilled. The engine must read it, see the done flag still set, and then stay off the memory port until the tail register is written again. To get there, the bench wraps the head onto a slot that was filled earlier. It then waits, confirms that no write appears, refills the slot, and rewrites the tail. A second hard case is filling the FIFO while the ring is empty. The bench does this by pushing a frame longer than the FIFO with no free slot, and then checks every beat once a slot is released. A slow grant pattern makes requests wait, so that the ordering of data beats and write-back is tested under stalls.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DESC_SHIFT = 4;
  localparam int DONE_BIT   = 63;
  localparam int LEN_LSB    = 32;
  localparam int LEN_W      = 16;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FWAIT, S_DATA, S_WB} rx_state_t;

  function automatic logic [31:0] desc_addr(logic [31:0] base, logic [31:0] idx);
    return {base[31:4], 4'b0000} + (idx << DESC_SHIFT);
  endfunction

  function automatic logic [31:0] next_index(logic [31:0] idx, logic [31:0] size);
    return ((idx + 32'd1) >= size) ? 32'd0 : idx + 32'd1;
  endfunction

  function automatic logic [31:0] beat_addr(logic [31:0] bufa, logic [31:0] beats, int shift);
    return bufa + (beats << shift);
  endfunction

  function automatic logic [63:0] wb_word(logic [31:0] bufa, logic [LEN_W-1:0] len);
    logic [63:0] w;
    w = '0;
    w[31:0] = bufa;
    w[LEN_LSB +: LEN_W] = len;
    w[DONE_BIT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     base,
  output logic [IDXW:0]   size,
  output logic [IDXW-1:0] tail,
  output logic            enable,
  output logic            tail_wr
);
  logic unused_bits;
  assign unused_bits = ^reg_wdata[31:IDXW+1];
  assign tail_wr = reg_we && (reg_sel == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      size   <= '0;
      tail   <= '0;
      enable <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: base   <= reg_wdata;
        2'd1: size   <= reg_wdata[IDXW:0];
        2'd2: tail   <= reg_wdata[IDXW-1:0];
        default: enable <= reg_wdata[0];
      endcase
    end
  end
endmodule

// File: rtl/rxr_fifo.sv
module rxr_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          pop
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW:0]   store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, take;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign take      = pop && out_valid;
  assign out_data  = store[rd_ptr][DW-1:0];
  assign out_last  = store[rd_ptr][DW];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= {in_last, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (take) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(take);
    end
  end
endmodule

// File: rtl/rxr_ring.sv
module rxr_ring #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic [IDXW:0]   size,
  input  logic [IDXW-1:0] tail,
  output logic [IDXW-1:0] head,
  output logic            slot_free
);
  import rxr_pkg::*;
  logic [31:0] nxt;
  logic        unused_hi;

  assign nxt       = next_index(32'(head), 32'(size));
  assign unused_hi = ^nxt[31:IDXW];
  assign slot_free = (head != tail);

  always_ff @(posedge clk) begin
    if (!rst_n)       head <= '0;
    else if (advance) head <= nxt[IDXW-1:0];
  end
endmodule

// File: rtl/rxr_dma_top.sv
module rxr_dma_top #(
  parameter int IDXW       = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);
  import rxr_pkg::*;
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int BEAT_W     = LEN_W - BEAT_SHIFT;

  logic [31:0]       base;
  logic [IDXW:0]     size;
  logic [IDXW-1:0]   tail, head_idx;
  logic              enable, tail_wr, slot_free;
  logic              fifo_valid, pop_last;
  logic [DATA_W-1:0] fifo_data;

  rx_state_t         state;
  logic [31:0]       buf_addr;
  logic [BEAT_W-1:0] beats;
  logic              blocked;

  // named internal events
  logic fetch_fire, data_fire, wb_fire, head_adv, can_start, stale_desc;
  logic [31:0] cur_desc;
  logic [LEN_W-1:0] len_bytes;
  logic unused_rd;

  assign unused_rd  = ^mem_rdata[62:32];
  assign cur_desc   = desc_addr(base, 32'(head_idx));
  assign len_bytes  = {beats, {BEAT_SHIFT{1'b0}}};
  assign can_start  = enable && (size != '0) && fifo_valid && slot_free && !blocked;
  assign fetch_fire = (state == S_FETCH) && mem_gnt;
  assign data_fire  = (state == S_DATA) && fifo_valid && mem_gnt;
  assign wb_fire    = (state == S_WB) && mem_gnt;
  assign head_adv   = wb_fire;
  assign stale_desc = (state == S_FWAIT) && mem_rvalid && mem_rdata[DONE_BIT];

  rxr_regs #(.IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .base(base), .size(size), .tail(tail),
    .enable(enable), .tail_wr(tail_wr)
  );

  rxr_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(fifo_valid),
    .out_data(fifo_data), .out_last(pop_last), .pop(data_fire)
  );

  rxr_ring #(.IDXW(IDXW)) u_ring (
    .clk(clk), .rst_n(rst_n), .advance(head_adv), .size(size),
    .tail(tail), .head(head_idx), .slot_free(slot_free)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_desc;
    mem_wdata = '0;
    case (state)
      S_FETCH: mem_req = 1'b1;
      S_DATA: begin
        mem_req   = fifo_valid;
        mem_we    = 1'b1;
        mem_addr  = beat_addr(buf_addr, 32'(beats), BEAT_SHIFT);
        mem_wdata = 64'(fifo_data);
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wb_word(buf_addr, len_bytes);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      buf_addr <= '0;
      beats    <= '0;
      blocked  <= 1'b0;
    end else begin
      if (tail_wr)         blocked <= 1'b0;
      else if (stale_desc) blocked <= 1'b1;
      case (state)
        S_IDLE:  if (can_start) state <= S_FETCH;
        S_FETCH: if (fetch_fire) state <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          if (mem_rdata[DONE_BIT]) state <= S_IDLE;
          else begin
            buf_addr <= mem_rdata[31:0];
            beats    <= '0;
            state    <= S_DATA;
          end
        end
        S_DATA: if (data_fire) begin
          beats <= beats + 1'b1;
          if (pop_last) state <= S_WB;
        end
        S_WB:    if (wb_fire) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int IDXW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [IDXW-1:0] head,
  input logic [IDXW-1:0] tail,
  input logic [IDXW:0]   size,
  input logic            fetch_fire,
  input logic            data_fire,
  input logic            pop_last,
  input logic            wb_fire,
  input logic            head_adv,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic            mem_we,
  input logic [31:0]     mem_addr,
  input logic [63:0]     mem_wdata
);
  logic saw_last;
  int   exp_head;

  always_ff @(posedge clk) begin
    if (!rst_n)                     saw_last <= 1'b0;
    else if (wb_fire)               saw_last <= 1'b0;
    else if (data_fire && pop_last) saw_last <= 1'b1;
  end

  always_comb begin
    exp_head = int'(head) + 1;
    if (exp_head >= int'(size)) exp_head = 0;
  end

  int exp_q;
  always_ff @(posedge clk) exp_q <= exp_head;

  p_no_fetch_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |-> (head != tail));

  p_head_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    head_adv |=> (int'(head) == exp_q));

  p_wb_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> saw_last);

  p_wb_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (mem_we && mem_wdata[63]));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind rxr_dma_top rxr_checker #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .head(head_idx), .tail(tail), .size(size),
  .fetch_fire(fetch_fire), .data_fire(data_fire), .pop_last(pop_last),
  .wb_fire(wb_fire), .head_adv(head_adv), .mem_req(mem_req),
  .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/sim_rxr_dma_top.sv
module sim_rxr_dma_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 32'h100;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic        in_valid = 0, in_last = 0;
  logic [63:0] in_data = 0;
  logic        in_ready, mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_gnt = 0, mem_rvalid = 0;
  logic [63:0] mem_rdata = 0;

  int checks = 0, fails = 0, cyc = 0, wr_count = 0, rd_count = 0, gnt_div = 1;
  logic [63:0] mem  [0:2047];
  int          wseq [0:2047];
  logic        rd_pend = 0;
  int          rd_idx = 0;
  bit          push_done = 0;

  rxr_dma_top u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // memory model: grants and writes decided at negedge, read data one cycle after grant
  always @(negedge clk) begin
    mem_rvalid = 0;
    if (rd_pend) begin
      mem_rvalid = 1;
      mem_rdata  = mem[rd_idx];
      rd_pend    = 0;
    end
    mem_gnt = mem_req && (gnt_div <= 1 || (cyc % gnt_div) == 0);
    if (mem_gnt) begin
      if (mem_we) begin
        wr_count++;
        mem[mem_addr[13:3]]  = mem_wdata;
        wseq[mem_addr[13:3]] = wr_count;
      end else begin
        rd_count++;
        rd_pend = 1;
        rd_idx  = int'(mem_addr[13:3]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int sel, input int val);
    @(negedge clk);
    reg_we = 1; reg_sel = 2'(sel); reg_wdata = 32'(val);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic push_frame(input int id, input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1;
      in_data  = {32'(id), 32'(k)};
      in_last  = (k == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  function automatic int didx(input int slot);
    return (BASE + 16 * slot) >> 3;
  endfunction

  task automatic set_desc(input int slot, input int bufa);
    mem[didx(slot)] = {32'h0, 32'(bufa)};
  endtask

  task automatic wait_done(input int slot);
    int t = 0;
    while (!mem[didx(slot)][63] && t < 3000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_frame(input int slot, input int bufa, input int id, input int n);
    logic [63:0] exp_wb;
    int maxseq = 0;
    wait_done(slot);
    exp_wb = {1'b1, 15'b0, 16'(8 * n), 32'(bufa)};
    check(mem[didx(slot)] == exp_wb, "R6 R9 R3 writeback word", mem[didx(slot)], exp_wb);
    for (int k = 0; k < n; k++) begin
      int a = (bufa + 8 * k) >> 3;
      check(mem[a] == {32'(id), 32'(k)}, "R8 data beat", mem[a], {32'(id), 32'(k)});
      if (wseq[a] > maxseq) maxseq = wseq[a];
    end
    check(wseq[didx(slot)] > maxseq, "R7 writeback after data",
          64'(wseq[didx(slot)]), 64'(maxseq + 1));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(mem_req == 0, "R1 mem_req after reset", 64'(mem_req), 0);
    check(in_ready == 1, "R1 in_ready after reset", 64'(in_ready), 1);
  endtask

  task automatic t_disabled_then_first;
    int w0;
    reg_write(0, BASE | 32'hF);  // low bits ignored
    reg_write(1, 4);
    reg_write(2, 3);
    w0 = wr_count;
    push_frame(1, 2);
    repeat (50) @(negedge clk);
    check(wr_count == w0 && rd_count == 0, "R2 no request while disabled", 64'(wr_count + rd_count), 64'(w0));
    reg_write(3, 1);
    check_frame(0, 32'h1000, 1, 2);
  endtask

  task automatic t_stalled_grants;
    gnt_div = 3;
    push_frame(2, 3);
    check_frame(1, 32'h1200, 2, 3);
    gnt_div = 1;
    push_frame(3, 1);
    check_frame(2, 32'h1400, 3, 1);
  endtask

  task automatic t_full_ring_and_wrap;
    int w0, r0;
    w0 = wr_count; r0 = rd_count;
    push_frame(4, 2);  // head = 3 = tail
    repeat (60) @(negedge clk);
    check(wr_count == w0 && rd_count == r0, "R5 no access while head equals tail",
          64'(wr_count + rd_count), 64'(w0 + r0));
    reg_write(2, 1);  // slots 3 and 0 offered
    check_frame(3, 32'h1600, 4, 2);
    // next frame lands on head 0 (R4 wrap), slot 0 still has done set
    w0 = wr_count;
    push_frame(5, 2);
    repeat (60) @(negedge clk);
    check(wr_count == w0, "R10 stale slot not written", 64'(wr_count), 64'(w0));
    r0 = rd_count;
    repeat (40) @(negedge clk);
    check(rd_count == r0, "R10 no refetch before tail write", 64'(rd_count), 64'(r0));
    set_desc(0, 32'h1800);
    reg_write(2, 1);
    check_frame(0, 32'h1800, 5, 2);  // R4: head wrapped to 0
  endtask

  task automatic t_backpressure;
    bit saw_low = 0;
    push_done = 0;
    fork
      begin push_frame(6, 20); push_done = 1; end
    join_none
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (!in_ready) saw_low = 1;
    end
    check(saw_low, "R11 in_ready low with full FIFO", 64'(saw_low), 1);
    check(!push_done, "R11 frame held back", 64'(push_done), 0);
    set_desc(1, 32'h1A00);
    reg_write(2, 2);
    check_frame(1, 32'h1A00, 6, 20);
    check(push_done, "R11 all beats accepted", 64'(push_done), 1);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin mem[i] = '0; wseq[i] = 0; end
    set_desc(0, 32'h1000);
    set_desc(1, 32'h1200);
    set_desc(2, 32'h1400);
    set_desc(3, 32'h1600);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled_then_first();
    t_stalled_grants();
    t_full_ring_and_wrap();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule